// File: doc/BRIEF.md
# Reset Mode Selector with Serial Boot Loader

This block decides how a processor core starts after reset. When reset is released it reads two mode-select pins once and latches one of four start-up modes. It then presents the address the core should fetch first and a run signal that lets the core out of reset.

Three of the modes start the core at once from the ROM start address. The boot-load mode is different. It keeps the core halted while a fixed-length program arrives over a byte-wide receive stream (valid plus data). Each accepted byte is written through a simple RAM write port to consecutive addresses, starting at the RAM base. When the final byte has been written, the core is released with the RAM base as its start address.

The serial receiver, the RAM itself and the core are outside the block.

Top module: `reset_mode_boot`

## Requirements
- R1: While `rst_n` is low, `cpu_run` and `ram_we` are 0.
- R2: Pins (`mode_pin_a`,`mode_pin_b`) = (0,1) select single-chip mode. `mode_o` reads 0 and `start_addr` reads 16'hE000. `cpu_run` is 1 from the first clock edge after reset is released.
- R3: Pins (1,1) select expanded mode. `mode_o` reads 1, `start_addr` reads 16'hE000 and `cpu_run` rises on the first edge after reset release.
- R4: Pins (1,0) select factory-test mode. `mode_o` reads 3, `start_addr` reads 16'hE000 and `cpu_run` rises on the first edge after reset release.
- R5: Pins (0,0) select boot-load mode. `mode_o` reads 2 and `start_addr` reads 16'h0000. `cpu_run` stays 0 until the download is complete.
- R6: In boot-load mode, each cycle with `rx_valid` high drives `ram_we`=1 in that same cycle, with `ram_wdata`=`rx_data`. The n-th accepted byte (counting from 0) goes to address n.
- R7: `cpu_run` is 0 in the cycle that carries the 256th byte. It is 1 from the next cycle on, and it stays 1 until reset.
- R8: Received bytes have no effect outside the download: `ram_we` stays 0 in the other modes and after the 256th byte.
- R9: The pins are read only on the first clock edge after reset release. Later pin changes leave `mode_o` and `start_addr` unchanged until the next reset.
- R10: Asserting reset during a download aborts it. The next boot-load download writes from address 0 again.
- R11: Cycles with `rx_valid` low during a download write nothing and do not advance the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_pin_a | input | 1 | First mode-select pin |
| mode_pin_b | input | 1 | Second mode-select pin |
| rx_valid | input | 1 | Received byte present this cycle |
| rx_data | input | 8 | Received byte |
| ram_we | output | 1 | RAM write enable |
| ram_waddr | output | 16 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| mode_o | output | 2 | Latched mode code (0 single, 1 expanded, 2 boot-load, 3 factory-test) |
| start_addr | output | 16 | First fetch address for the core |
| cpu_run | output | 1 | Releases the core from reset when high |

## Verification
The hardest situations to reach are at the ends of the download: the exact cycle in which the core is released after byte 256, and an abort in the middle of a download followed by a fresh count from zero. The stimulus drives full 256-byte downloads, both back to back and with idle gaps, and checks the run signal in the cycle of the last byte and in the cycle after it. It also resets partway through a download and checks that the following run starts writing at address 0. While each download is in progress it toggles the mode pins, and once the core is running it keeps sending bytes, so that the ignored stimulus is observed at the ports.

// File: rtl/bootsel_pkg.sv
package bootsel_pkg;

   typedef enum logic [1:0] {
      MD_SINGLE   = 2'd0,
      MD_EXPANDED = 2'd1,
      MD_BOOTLOAD = 2'd2,
      MD_FACTORY  = 2'd3
   } op_mode_t;

   typedef enum logic [1:0] {
      PH_SAMPLE = 2'd0,
      PH_LOAD   = 2'd1,
      PH_RUN    = 2'd2
   } phase_t;

   // Pin pair (a,b) to start-up mode
   function automatic op_mode_t pins_to_mode(input logic sel_a, input logic sel_b);
      op_mode_t m;
      case ({sel_a, sel_b})
         2'b01:   m = MD_SINGLE;
         2'b11:   m = MD_EXPANDED;
         2'b00:   m = MD_BOOTLOAD;
         default: m = MD_FACTORY;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/bootsel_mode_latch.sv
module bootsel_mode_latch
   import bootsel_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  op_mode_t pin_mode,
   output op_mode_t mode_q,
   output logic     sample_now
);

   logic taken_q;

   assign sample_now = !taken_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         taken_q <= 1'b0;
         mode_q  <= MD_SINGLE;
      end else if (!taken_q) begin
         taken_q <= 1'b1;
         mode_q  <= pin_mode;
      end
   end

   // R9
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      taken_q |=> $stable(mode_q));

endmodule

// File: rtl/bootsel_load_counter.sv
module bootsel_load_counter #(
   parameter int LOAD_BYTES = 256,
   parameter int CNT_W      = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             rx_valid,
   output logic [CNT_W-1:0] count,
   output logic             accept,
   output logic             last_beat
);

   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(LOAD_BYTES - 1);

   initial begin
      cnt_range_chk: assert (LOAD_BYTES >= 2 && (1 << CNT_W) >= LOAD_BYTES)
         else $error("load counter too narrow for LOAD_BYTES");
   end

   assign accept    = enable && rx_valid;
   assign last_beat = accept && (count == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (accept) begin
         count <= last_beat ? '0 : count + CNT_W'(1);
      end
   end

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !rx_valid) |=> $stable(count));

   // R6
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !last_beat) |=> (count == $past(count) + CNT_W'(1)));

endmodule

// File: rtl/bootsel_sequencer.sv
module bootsel_sequencer
   import bootsel_pkg::*;
#(
   parameter int              AW        = 16,
   parameter logic [AW-1:0]   ROM_START = 16'hE000,
   parameter logic [AW-1:0]   RAM_BASE  = 16'h0000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sample_now,
   input  op_mode_t      pin_mode,
   input  logic          last_beat,
   output logic          load_en,
   output logic          cpu_run,
   output logic [AW-1:0] start_addr
);

   phase_t phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_SAMPLE;
         start_addr <= '0;
      end else begin
         case (phase)
            PH_SAMPLE: begin
               if (sample_now) begin
                  if (pin_mode == MD_BOOTLOAD) begin
                     phase      <= PH_LOAD;
                     start_addr <= RAM_BASE;
                  end else begin
                     phase      <= PH_RUN;
                     start_addr <= ROM_START;
                  end
               end
            end
            PH_LOAD: if (last_beat) phase <= PH_RUN;
            default: phase <= PH_RUN;
         endcase
      end
   end

   assign load_en = (phase == PH_LOAD);
   assign cpu_run = (phase == PH_RUN);

   // R7
   run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_run |=> cpu_run);

   // R7
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en && last_beat) |=> cpu_run);

   // R5
   hold_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_en && !last_beat) |=> !cpu_run);

endmodule

// File: rtl/reset_mode_boot.sv
module reset_mode_boot
   import bootsel_pkg::*;
#(
   parameter int            AW         = 16,
   parameter int            DW         = 8,
   parameter int            LOAD_BYTES = 256,
   parameter logic [AW-1:0] ROM_START  = 16'hE000,
   parameter logic [AW-1:0] RAM_BASE   = 16'h0000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_pin_a,
   input  logic          mode_pin_b,
   input  logic          rx_valid,
   input  logic [DW-1:0] rx_data,
   output logic          ram_we,
   output logic [AW-1:0] ram_waddr,
   output logic [DW-1:0] ram_wdata,
   output logic [1:0]    mode_o,
   output logic [AW-1:0] start_addr,
   output logic          cpu_run
);

   localparam int CNT_W = $clog2(LOAD_BYTES);

   initial begin
      aw_fit_chk: assert (AW > CNT_W)
         else $error("address width must exceed load counter width");
   end

   op_mode_t         pin_mode;
   op_mode_t         mode_q;
   logic             sample_now;
   logic             load_en;
   logic             last_beat;
   logic [CNT_W-1:0] count;

   assign pin_mode = pins_to_mode(mode_pin_a, mode_pin_b);

   bootsel_mode_latch u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_mode   (pin_mode),
      .mode_q     (mode_q),
      .sample_now (sample_now)
   );

   bootsel_sequencer #(
      .AW        (AW),
      .ROM_START (ROM_START),
      .RAM_BASE  (RAM_BASE)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_now (sample_now),
      .pin_mode   (pin_mode),
      .last_beat  (last_beat),
      .load_en    (load_en),
      .cpu_run    (cpu_run),
      .start_addr (start_addr)
   );

   bootsel_load_counter #(
      .LOAD_BYTES (LOAD_BYTES),
      .CNT_W      (CNT_W)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (load_en),
      .rx_valid  (rx_valid),
      .count     (count),
      .accept    (ram_we),
      .last_beat (last_beat)
   );

   // Aligned base: splice the counter in; otherwise add it
   generate
      if (RAM_BASE[CNT_W-1:0] == '0) begin : g_splice
         assign ram_waddr = {RAM_BASE[AW-1:CNT_W], count};
      end else begin : g_add
         assign ram_waddr = RAM_BASE + AW'(count);
      end
   endgenerate

   assign ram_wdata = rx_data;
   assign mode_o    = mode_q;

   // R8
   no_write_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> !cpu_run);

   // R5
   boot_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_run && mode_q == MD_BOOTLOAD) |-> (start_addr == RAM_BASE));

endmodule

// File: tb/test_reset_mode_boot.sv
`timescale 1ns/1ps
module test_reset_mode_boot;
   localparam int AW = 16;
   localparam int NB = 256;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pa = 1'b0, pb = 1'b0;
   logic          rx_valid = 1'b0;
   logic [7:0]    rx_data = '0;
   logic          ram_we;
   logic [AW-1:0] ram_waddr;
   logic [7:0]    ram_wdata;
   logic [1:0]    mode_o;
   logic [AW-1:0] start_addr;
   logic          cpu_run;

   reset_mode_boot i_reset_mode_boot (
      .clk(clk), .rst_n(rst_n), .mode_pin_a(pa), .mode_pin_b(pb),
      .rx_valid(rx_valid), .rx_data(rx_data), .ram_we(ram_we),
      .ram_waddr(ram_waddr), .ram_wdata(ram_wdata), .mode_o(mode_o),
      .start_addr(start_addr), .cpu_run(cpu_run));

   always #2.5 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   int exp_addr = 0;

   typedef struct packed { logic [AW-1:0] a; logic [7:0] d; } wr_t;
   wr_t exp_q[$];

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Monitor: every write must match the next expected item
   always @(negedge clk) begin
      wr_t e;
      if (rst_n && ram_we) begin
         if (exp_q.size() == 0) check("R8 write with nothing expected", 1, 0);
         else begin
            e = exp_q.pop_front();
            check("R6 write address", 32'(ram_waddr), 32'(e.a));
            check("R6 write data", 32'(ram_wdata), 32'(e.d));
         end
      end
   end

   task automatic reset_with(input logic a, input logic b);
      @(posedge clk); #1;
      rst_n = 1'b0; rx_valid = 1'b0; pa = a; pb = b;
      @(negedge clk);
      check("R1 cpu_run in reset", 32'(cpu_run), 0);
      check("R1 ram_we in reset", 32'(ram_we), 0);
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      exp_addr = 0;
   endtask

   task automatic send_byte(input logic [7:0] d);
      @(posedge clk); #1;
      rx_valid = 1'b1; rx_data = d;
      exp_q.push_back('{a: AW'(exp_addr), d: d});
      exp_addr++;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk); #1 rx_valid = 1'b0;
         @(negedge clk);
         check("R11 no write when idle", 32'(ram_we), 0);
      end
   endtask

   task automatic download(input logic gaps, input logic [7:0] seed);
      for (int i = 0; i < NB; i++) begin
         send_byte(8'(i * 7) ^ seed);
         if (i == 100) begin pa = ~pa; pb = ~pb; end
         if (gaps && (i % 5 == 4) && i != NB - 1) idle(2);
      end
      @(negedge clk);
      check("R7 held during last byte", 32'(cpu_run), 0);
      @(posedge clk); #1 rx_valid = 1'b0;
      @(negedge clk);
      check("R7 released after last byte", 32'(cpu_run), 1);
      check("R6 all bytes written", 32'(exp_q.size()), 0);
      check("R9 mode kept through download", 32'(mode_o), 2);
      check("R9 start kept through download", 32'(start_addr), 32'h0000);
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R2 single-chip
      reset_with(1'b0, 1'b1);
      check("R2 mode", 32'(mode_o), 0);
      check("R2 start", 32'(start_addr), 32'hE000);
      check("R2 run", 32'(cpu_run), 1);
      // R9 later pin change ignored
      pa = 1'b0; pb = 1'b0;
      idle(4);
      check("R9 mode unchanged", 32'(mode_o), 0);
      check("R9 start unchanged", 32'(start_addr), 32'hE000);
      // R8 bytes ignored in non-boot mode
      for (int k = 0; k < 3; k++) begin
         @(posedge clk); #1 rx_valid = 1'b1; rx_data = 8'hA5;
         @(negedge clk);
         check("R8 no write in single mode", 32'(ram_we), 0);
      end

      // R3 expanded
      reset_with(1'b1, 1'b1);
      check("R3 mode", 32'(mode_o), 1);
      check("R3 start", 32'(start_addr), 32'hE000);
      check("R3 run", 32'(cpu_run), 1);

      // R4 factory test
      reset_with(1'b1, 1'b0);
      check("R4 mode", 32'(mode_o), 3);
      check("R4 start", 32'(start_addr), 32'hE000);
      check("R4 run", 32'(cpu_run), 1);

      // R5 boot-load, then R10 abort mid-download
      reset_with(1'b0, 1'b0);
      check("R5 mode", 32'(mode_o), 2);
      check("R5 start", 32'(start_addr), 32'h0000);
      check("R5 core held", 32'(cpu_run), 0);
      for (int i = 0; i < 10; i++) send_byte(8'hC0 + 8'(i));
      idle(1);
      check("R10 partial bytes consumed", 32'(exp_q.size()), 0);
      check("R5 still held mid-download", 32'(cpu_run), 0);

      // R10 restart from address 0 after reset, with gaps (R11)
      reset_with(1'b0, 1'b0);
      check("R10 held after abort", 32'(cpu_run), 0);
      download(1'b1, 8'h5A);

      // R8 bytes after completion ignored
      for (int k = 0; k < 4; k++) begin
         @(posedge clk); #1 rx_valid = 1'b1; rx_data = 8'h3C;
         @(negedge clk);
         check("R8 no write after download", 32'(ram_we), 0);
         check("R7 run stays high", 32'(cpu_run), 1);
      end

      // back-to-back download
      reset_with(1'b0, 1'b0);
      download(1'b0, 8'h00);

      idle(2);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule